// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard-resolution control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Since every instruction reads its registers in decode and writes them in write-back, only read-after-write dependences can arise. The unit looks at the register numbers and flags carried by the decode/execute, execute/memory and memory/write-back latches. It produces a 2-bit bypass select for each of the two ALU operands of the instruction now in execute. It also produces the front-end controls that freeze fetch and decode and inject a bubble into execute.

ALU-to-ALU dependences never stall: the youngest in-flight producer is bypassed straight to the ALU input. A load read by the instruction right behind it is the one case that bypassing cannot cover, because the loaded word only exists after the memory stage. For that case the unit holds fetch and decode for exactly one cycle and sends a bubble into execute. A write to register zero is never treated as a producer. The register file is assumed to write in the first half of a cycle and read in the second, so a write-back producer and a decode consumer in the same cycle need no bypass.

A two-state machine enforces the single-bubble rule. State `ST_RUN` is the normal state. The transition `RUN->BUBBLE` is taken when a load-use hazard is detected, and the stall controls are raised in that same cycle. State `ST_BUBBLE` lasts one cycle, while the bubble sits in execute, and stall detection is masked there. The transition `BUBBLE->RUN` is unconditional. Reset enters `ST_RUN`.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After reset the machine is in ST_RUN. With all inputs at zero, both selects read 00 and hold_front and bubble_ex are low.
- R2: If the execute/memory latch writes a nonzero register equal to an operand's source in execute, that operand's select is 01.
- R3: If only the memory/write-back latch writes a nonzero register equal to an operand's source in execute, that operand's select is 10.
- R4: If both latches match the same source, the select is 01, so the younger producer wins.
- R5: With no matching enabled producer, the select is 00, meaning the register file value.
- R6: Register 0 never forwards, and a load targeting register 0 never stalls.
- R7: A load in execute whose nonzero destination equals a source that the decode instruction uses raises hold_front and bubble_ex together, in the same cycle.
- R8: A non-load producer in execute never causes a stall.
- R9: A decode source whose use flag is 0 never causes a stall.
- R10: A stall lasts exactly one cycle. In the cycle after a stall, hold_front is low whatever the inputs are.
- R11: The select code 11 never appears, and each operand's select depends only on its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| id_use1 | input | 1 | Decode instruction reads id_rs1 |
| id_use2 | input | 1 | Decode instruction reads id_rs2 |
| ex_rs1 | input | AW | First source register held in the decode/execute latch |
| ex_rs2 | input | AW | Second source register held in the decode/execute latch |
| ex_rd | input | AW | Destination held in the decode/execute latch |
| ex_wen | input | 1 | Decode/execute instruction writes a register |
| ex_load | input | 1 | Decode/execute instruction is a load |
| mem_rd | input | AW | Destination held in the execute/memory latch |
| mem_wen | input | 1 | Execute/memory instruction writes a register |
| wb_rd | input | AW | Destination held in the memory/write-back latch |
| wb_wen | input | 1 | Memory/write-back instruction writes a register |
| fwd_sel_a | output | 2 | ALU operand A source: 00 register file, 01 execute/memory, 10 memory/write-back |
| fwd_sel_b | output | 2 | ALU operand B source, same encoding |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode latch |
| bubble_ex | output | 1 | Load a bubble into the decode/execute latch |

## Verification
The checker tests properties on every cycle. The select code 11 never appears. A zero source register never forwards. A stall never follows a stall. The two stall outputs always agree. Neither a non-load producer nor a zero destination ever causes a stall. Bypass priority between the two latches, the exact select value in each dependence pattern, and the effect of unused source flags can only be shown by the bench. It uses directed scenarios and a seeded random stream compared against an independent scoreboard that models the one-bubble rule.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_EXMEM = 2'b01,
        SEL_MEMWB = 2'b10
    } sel_t;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BUBBLE = 1'b1
    } ilk_state_t;
endpackage

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output sel_t          sel
);
    logic hit_mem;
    logic hit_wb;

    assign hit_mem = mem_wen && (mem_rd != '0) && (mem_rd == src);
    assign hit_wb  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);

    // Younger producer (execute/memory) takes priority.
    always_comb begin
        if (hit_mem)     sel = SEL_EXMEM;
        else if (hit_wb) sel = SEL_MEMWB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [NSRC-1:0]         id_use,
    input  logic [AW-1:0]           ex_rd,
    input  logic                    ex_wen,
    input  logic                    ex_load,
    output logic                    hazard
);
    logic [NSRC-1:0] hit;
    logic            producer_ok;

    assign producer_ok = ex_load && ex_wen && (ex_rd != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = id_use[i] && (id_src[i] == ex_rd);
    end

    assign hazard = producer_ok && (|hit);
endmodule

// File: rtl/interlock_fsm.sv
module interlock_fsm
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic hold
);
    ilk_state_t state_q;
    ilk_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hold    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hold = hazard;
                if (hazard) state_d = ST_BUBBLE;   // RUN->BUBBLE
            end
            ST_BUBBLE: begin
                hold    = 1'b0;                    // bubble is in execute
                state_d = ST_RUN;                  // BUBBLE->RUN
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use1,
    input  logic          id_use2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          hold_front,
    output logic          bubble_ex
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][AW-1:0] ex_src;
    logic [NSRC-1:0][AW-1:0] id_src;
    logic [NSRC-1:0]         id_use;
    sel_t [NSRC-1:0]         sel;
    logic                    hazard;
    logic                    hold;

    assign ex_src = {ex_rs2, ex_rs1};
    assign id_src = {id_rs2, id_rs1};
    assign id_use = {id_use2, id_use1};

    for (genvar i = 0; i < NSRC; i++) begin : g_op
        fwd_sel_unit #(.AW(AW)) u_sel (
            .src     (ex_src[i]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (sel[i])
        );
    end

    load_use_detect #(.AW(AW), .NSRC(NSRC)) u_det (
        .id_src  (id_src),
        .id_use  (id_use),
        .ex_rd   (ex_rd),
        .ex_wen  (ex_wen),
        .ex_load (ex_load),
        .hazard  (hazard)
    );

    interlock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (hazard),
        .hold   (hold)
    );

    assign fwd_sel_a  = sel[0];
    assign fwd_sel_b  = sel[1];
    assign hold_front = hold;
    assign bubble_ex  = hold;
endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic [AW-1:0] ex_rd,
    input logic          ex_load,
    input logic [1:0]    fwd_sel_a,
    input logic [1:0]    fwd_sel_b,
    input logic          hold_front,
    input logic          bubble_ex
);
    p_sel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    p_zero_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_rs1 == '0) |-> (fwd_sel_a == 2'b00)) and
        ((ex_rs2 == '0) |-> (fwd_sel_b == 2'b00)));

    p_zero_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !hold_front);

    p_stall_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front == bubble_ex);

    p_nonload_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !hold_front);

    p_single_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |=> !hold_front);
endmodule

bind fwd_interlock_unit fwd_interlock_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_rs1     (ex_rs1),
    .ex_rs2     (ex_rs2),
    .ex_rd      (ex_rd),
    .ex_load    (ex_load),
    .fwd_sel_a  (fwd_sel_a),
    .fwd_sel_b  (fwd_sel_b),
    .hold_front (hold_front),
    .bubble_ex  (bubble_ex)
);

// File: tb/test_fwd_interlock_unit.sv
module test_fwd_interlock_unit;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          id_use1, id_use2, ex_wen, ex_load, mem_wen, wb_wen;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          hold_front, bubble_ex;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit prev_hold = 1'b0;

    always #5 clk = ~clk;

    fwd_interlock_unit #(.AW(AW)) i_fwd_interlock_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .hold_front(hold_front), .bubble_ex(bubble_ex)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        id_rs1 = '0; id_rs2 = '0; id_use1 = 0; id_use2 = 0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_wen = 0; ex_load = 0;
        mem_rd = '0; mem_wen = 0; wb_rd = '0; wb_wen = 0;
    endtask

    // Idle cycle: brings the interlock back to its run state.
    task automatic idle();
        @(negedge clk);
        clear_in();
        @(negedge clk);
    endtask

    function automatic int ref_sel(input logic [AW-1:0] s);
        if (mem_wen && mem_rd != 0 && mem_rd == s) return 1;
        if (wb_wen && wb_rd != 0 && wb_rd == s) return 2;
        return 0;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sel_a", fwd_sel_a, 0);
        chk("R1 sel_b", fwd_sel_b, 0);
        chk("R1 hold", hold_front, 0);
        chk("R1 bubble", bubble_ex, 0);
    endtask

    task automatic t_exmem();
        idle(); ex_rs1 = 3; ex_rs2 = 9; mem_rd = 3; mem_wen = 1; #1;
        chk("R2 sel_a", fwd_sel_a, 1);
        chk("R11 sel_b independent", fwd_sel_b, 0);
    endtask

    task automatic t_memwb();
        idle(); ex_rs1 = 4; ex_rs2 = 7; wb_rd = 7; wb_wen = 1; #1;
        chk("R3 sel_b", fwd_sel_b, 2);
        chk("R11 sel_a independent", fwd_sel_a, 0);
    endtask

    task automatic t_priority();
        idle(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1; #1;
        chk("R4 sel_a", fwd_sel_a, 1);
        chk("R4 sel_b", fwd_sel_b, 1);
    endtask

    task automatic t_nofwd();
        idle(); ex_rs1 = 6; mem_rd = 6; mem_wen = 0; wb_rd = 6; wb_wen = 0; #1;
        chk("R5 sel_a disabled", fwd_sel_a, 0);
        idle(); ex_rs2 = 6; mem_rd = 8; mem_wen = 1; wb_rd = 2; wb_wen = 1; #1;
        chk("R5 sel_b mismatch", fwd_sel_b, 0);
    endtask

    task automatic t_zero();
        idle(); mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; #1;
        chk("R6 sel_a r0", fwd_sel_a, 0);
        chk("R6 sel_b r0", fwd_sel_b, 0);
        idle(); ex_load = 1; ex_wen = 1; ex_rd = 0; id_rs1 = 0; id_use1 = 1; #1;
        chk("R6 load r0 hold", hold_front, 0);
    endtask

    task automatic t_load_use();
        idle(); ex_load = 1; ex_wen = 1; ex_rd = 4; id_rs2 = 4; id_use2 = 1; #1;
        chk("R7 hold", hold_front, 1);
        chk("R7 bubble", bubble_ex, 1);
        @(negedge clk); #1;
        chk("R10 hold after stall", hold_front, 0);
        chk("R10 bubble after stall", bubble_ex, 0);
    endtask

    task automatic t_alu_nostall();
        idle(); ex_load = 0; ex_wen = 1; ex_rd = 12; id_rs1 = 12; id_use1 = 1; #1;
        chk("R8 hold", hold_front, 0);
    endtask

    task automatic t_unused();
        idle(); ex_load = 1; ex_wen = 1; ex_rd = 13; id_rs1 = 13; id_use1 = 0; #1;
        chk("R9 hold", hold_front, 0);
    endtask

    task automatic t_random();
        int unsigned seed_v;
        bit exp_hold;
        idle();
        prev_hold = 0;
        seed_v = $urandom(42);
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            id_use1 = 1'($urandom); id_use2 = 1'($urandom);
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd = AW'($urandom_range(0, 3)); ex_wen = 1'($urandom); ex_load = 1'($urandom);
            mem_rd = AW'($urandom_range(0, 3)); mem_wen = 1'($urandom);
            wb_rd = AW'($urandom_range(0, 3)); wb_wen = 1'($urandom);
            #1;
            exp_hold = !prev_hold && ex_load && ex_wen && ex_rd != 0 &&
                       ((id_use1 && id_rs1 == ex_rd) || (id_use2 && id_rs2 == ex_rd));
            chk("R2-sel_a random", fwd_sel_a, ref_sel(ex_rs1));
            chk("R3-sel_b random", fwd_sel_b, ref_sel(ex_rs2));
            chk("R10 random hold", hold_front, exp_hold);
            chk("R7 random bubble", bubble_ex, exp_hold);
            prev_hold = exp_hold;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_exmem();
        t_memwb();
        t_priority();
        t_nofwd();
        t_zero();
        t_load_use();
        t_alu_nostall();
        t_unused();
        t_random();
        idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule